// File: doc/BRIEF.md
# Black Key Unwrap Unit

This block rebuilds a device's working (red) key from two halves: a wrapped key held outside the chip (the black key) and a device-unique key produced on chip (the PUF key). The red key is the bitwise XOR of the two. After every reset the unit fills its three key registers with pseudo-random values. It then captures the black key and waits for the PUF key's valid strobe. Next it forms the red key. It raises a ready flag that stays high until the next reset.

Two unwrap sequences are offered. In parallel mode all bits are combined in one step. In serial mode the black and PUF registers shift out one bit per clock into a single XOR gate, and that gate feeds a red-key shift register. Two measures make optical probing of the key registers harder. The first is the random fill after reset, taken from an LFSR that is seeded from an input, so that registers holding a zero still toggle in a reset loop. The second is a fixed permutation parameter that places key bits at scrambled physical positions. The output port always presents the red key in logical bit order.

Top module: `key_unwrap`

## Requirements
- R1: While `ready_o` is low, `red_key_o` reads all zeros. This holds after reset and during an unwrap.
- R2: `black_key_i` is captured on the third rising clock edge after `rst_ni` goes high. Later changes to it have no effect on the result.
- R3: `puf_valid_i` is accepted only on rising edges after the black key has been captured. A strobe held during the first three edges is ignored, and the PUF key used is the one present at the first edge that accepts it.
- R4: In parallel mode (`mode_i` = 0), `ready_o` rises on the first rising edge after the edge that accepted `puf_valid_i`.
- R5: In serial mode (`mode_i` = 1), `ready_o` rises on the eighth (KEY_W-th) rising edge after the edge that accepted `puf_valid_i`.
- R6: In both modes, `red_key_o` equals black key XOR PUF key, bit i of the output being bit i of each input. For example, 8'b10101101 with 8'b11011011 gives 8'b01110110.
- R7: Each key register block takes new data once per reset. Once `ready_o` is high, it and `red_key_o` hold until reset, whatever the later values of `puf_valid_i`, `puf_key_i`, `black_key_i` and `mode_i`.
- R8: The value of `seed_i`, including zero, never changes the red key or the ready latency.
- R9: `mode_i` is sampled on the same edge as the black key. Later changes to it have no effect on latency or result.
- R10: The red key at the port is the same for any valid bit permutation parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| black_key_i | input | KEY_W | Wrapped key from external storage |
| puf_key_i | input | KEY_W | Device-unique key from the PUF |
| puf_valid_i | input | 1 | PUF key is complete |
| mode_i | input | 1 | 0 parallel unwrap, 1 serial unwrap |
| seed_i | input | LFSR_W | Seed for the reset-fill LFSR |
| red_key_o | output | KEY_W | Recovered key, logical bit order, zero until ready |
| ready_o | output | 1 | Red key valid |

## Verification
The XOR is tried with a mixed vector and its known answer, with all-ones against all-zeros, with equal keys that cancel to zero, and with single bits at opposite ends. These patterns separate a correct XOR from a dropped bit, a reversed shift order or a permutation that is not undone at the output. Every pattern runs in both modes. The measured latency (1 against 8 edges) shows which sequence actually ran. Results are compared with a second instance that uses the identity permutation and no random fill, and are repeated across several seeds, including zero. These comparisons expose any leak from the random fill or from the scrambling. Late edits to the key, the strobe or the mode, and a strobe given too early, show whether the capture windows are right.

// File: rtl/ku_pkg.sv
package ku_pkg;

    typedef enum logic [2:0] {
        ST_SEED  = 3'd0,
        ST_FILL  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_XOR   = 3'd4,
        ST_SHIFT = 3'd5,
        ST_DONE  = 3'd6
    } ku_state_e;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } ku_mode_e;

endpackage

// File: rtl/ku_lfsr.sv
module ku_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY = 16'hB400
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [WIDTH-1:0] NONZERO = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] lfsr_d, lfsr_q;

    always_comb begin
        if (load_i) begin
            // an all-zero state would lock the register
            lfsr_d = (seed_i == '0) ? NONZERO : seed_i;
        end else begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? POLY : '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= NONZERO;
        else         lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

    p_lfsr_alive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0);

endmodule

// File: rtl/ku_perm.sv
module ku_perm #(
    parameter int                       W     = 8,
    parameter int                       IDX_W = 3,
    parameter logic [W*IDX_W-1:0]       PERM  = 24'o76543210,
    parameter bit                       INV   = 1'b0
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    // physical position p holds logical bit PERM[p]
    for (genvar p = 0; p < W; p++) begin : g_bit
        localparam int LOG = int'(PERM[p*IDX_W +: IDX_W]);
        if (INV) begin : g_inv
            assign out_o[LOG] = in_i[p];
        end else begin : g_fwd
            assign out_o[p] = in_i[LOG];
        end
    end

endmodule

// File: rtl/key_unwrap.sv
module key_unwrap
    import ku_pkg::*;
#(
    parameter int                                KEY_W     = 8,
    parameter int                                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]                 LFSR_POLY = 16'hB400,
    parameter bit                                RAND_EN   = 1'b1,
    parameter logic [KEY_W*$clog2(KEY_W)-1:0]    PERM      = 24'o41630725
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [KEY_W-1:0]  black_key_i,
    input  logic [KEY_W-1:0]  puf_key_i,
    input  logic              puf_valid_i,
    input  logic              mode_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic [KEY_W-1:0]  red_key_o,
    output logic              ready_o
);

    localparam int               IDX_W    = $clog2(KEY_W);
    localparam int               CNT_W    = $clog2(KEY_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(KEY_W - 1);

    typedef struct packed {
        ku_state_e        state;
        ku_mode_e         mode;
        logic [KEY_W-1:0] black;
        logic [KEY_W-1:0] puf;
        logic [KEY_W-1:0] red;
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } ku_regs_t;

    ku_regs_t q, d;

    logic [LFSR_W-1:0] lfsr_val;
    logic [KEY_W-1:0]  black_phys, puf_phys, red_log;

    ku_lfsr #(.WIDTH(LFSR_W), .POLY(LFSR_POLY)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (q.state == ST_SEED),
        .seed_i  (seed_i),
        .state_o (lfsr_val)
    );

    ku_perm #(.W(KEY_W), .IDX_W(IDX_W), .PERM(PERM), .INV(1'b0)) u_perm_black (
        .in_i (black_key_i), .out_o(black_phys)
    );

    ku_perm #(.W(KEY_W), .IDX_W(IDX_W), .PERM(PERM), .INV(1'b0)) u_perm_puf (
        .in_i (puf_key_i), .out_o(puf_phys)
    );

    ku_perm #(.W(KEY_W), .IDX_W(IDX_W), .PERM(PERM), .INV(1'b1)) u_perm_red (
        .in_i (q.red), .out_o(red_log)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_SEED: d.state = ST_FILL;
            ST_FILL: begin
                if (RAND_EN) begin
                    d.black = lfsr_val[KEY_W-1:0];
                    d.puf   = ~lfsr_val[KEY_W-1:0];
                    d.red   = lfsr_val[LFSR_W-1 -: KEY_W];
                end
                d.state = ST_LOAD;
            end
            ST_LOAD: begin
                d.black = black_phys;
                d.mode  = ku_mode_e'(mode_i);
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (puf_valid_i) begin
                    d.puf   = puf_phys;
                    d.cnt   = '0;
                    d.state = (q.mode == MODE_PAR) ? ST_XOR : ST_SHIFT;
                end
            end
            ST_XOR: begin
                d.red   = q.black ^ q.puf;
                d.ready = 1'b1;
                d.state = ST_DONE;
            end
            ST_SHIFT: begin
                // bit 0 leaves first; the shift-in stage is the top bit
                d.black = q.black >> 1;
                d.puf   = q.puf >> 1;
                d.red   = {q.black[0] ^ q.puf[0], q.red[KEY_W-1:1]};
                d.cnt   = q.cnt + 1'b1;
                if (q.cnt == CNT_LAST) begin
                    d.ready = 1'b1;
                    d.state = ST_DONE;
                end
            end
            ST_DONE: d.state = ST_DONE;
            default: d.state = ST_DONE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= ST_SEED;
            q.mode  <= MODE_PAR;
            q.black <= '0;
            q.puf   <= '0;
            q.red   <= '0;
            q.cnt   <= '0;
            q.ready <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ready_o   = q.ready;
    assign red_key_o = q.ready ? red_log : '0;

    p_out_blank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> red_key_o == '0);

    p_black_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WAIT) |=> (q.state != ST_WAIT) || $stable(q.black));

    p_par_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WAIT && puf_valid_i && q.mode == MODE_PAR)
            |=> !ready_o ##1 ready_o);

    p_ser_no_early_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_SHIFT && q.cnt != CNT_LAST) |=> !ready_o && q.state == ST_SHIFT);

    p_ready_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o && $stable(red_key_o));

    p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state inside {ST_WAIT, ST_XOR, ST_SHIFT, ST_DONE}) |=> $stable(q.mode));

endmodule

// File: tb/tb_key_unwrap.sv
module tb_key_unwrap;

    localparam int KEY_W  = 8;
    localparam int LFSR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [KEY_W-1:0]  black_key = '0;
    logic [KEY_W-1:0]  puf_key = '0;
    logic              puf_valid = 1'b0;
    logic              mode = 1'b0;
    logic [LFSR_W-1:0] seed = 16'h1234;
    logic [KEY_W-1:0]  red_key, red_plain;
    logic              ready, ready_plain;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    key_unwrap dut (
        .clk_i(clk), .rst_ni(rst_n), .black_key_i(black_key), .puf_key_i(puf_key),
        .puf_valid_i(puf_valid), .mode_i(mode), .seed_i(seed),
        .red_key_o(red_key), .ready_o(ready)
    );

    key_unwrap #(.RAND_EN(1'b0), .PERM(24'o76543210)) dut_plain (
        .clk_i(clk), .rst_ni(rst_n), .black_key_i(black_key), .puf_key_i(puf_key),
        .puf_valid_i(puf_valid), .mode_i(mode), .seed_i(seed),
        .red_key_o(red_plain), .ready_o(ready_plain)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reset, then let edges 1..3 pass so the black key and mode are captured
    task automatic start(input logic [7:0] bk, input bit md, input logic [15:0] sd);
        @(negedge clk);
        rst_n = 1'b0; black_key = bk; mode = md; seed = sd; puf_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(ready == 1'b0, "R1 ready after reset", int'(ready), 0);
        chk(red_key == '0, "R1 key after reset", int'(red_key), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic feed_puf(input logic [7:0] pk);
        puf_key = pk; puf_valid = 1'b1;
        @(negedge clk);
        puf_valid = 1'b0;
    endtask

    task automatic wait_ready(output int lat);
        lat = 0;
        while (!ready && lat < 30) begin
            if (red_key != '0) chk(1'b0, "R1 key blank while busy", int'(red_key), 0);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_unwrap(input logic [7:0] bk, input logic [7:0] pk, input bit md,
                            input logic [15:0] sd, input string tag);
        int lat;
        start(bk, md, sd);
        feed_puf(pk);
        wait_ready(lat);
        if (md) chk(lat == KEY_W, {"R5 serial latency ", tag}, lat, KEY_W);
        else    chk(lat == 1,     {"R4 parallel latency ", tag}, lat, 1);
        chk(red_key == (bk ^ pk), {"R6 xor value ", tag}, int'(red_key), int'(bk ^ pk));
        chk(red_key == red_plain && ready_plain, {"R10 perm invisible ", tag},
            int'(red_key), int'(red_plain));
    endtask

    task automatic t_seeds();
        logic [15:0] seeds [3] = '{16'h0000, 16'h0001, 16'hABCD};
        for (int i = 0; i < 3; i++) begin
            int lat;
            start(8'hC3, 1'b1, seeds[i]);
            feed_puf(8'h5A);
            wait_ready(lat);
            chk(lat == KEY_W && red_key == 8'h99, "R8 seed independent", int'(red_key), 'h99);
        end
    endtask

    task automatic t_hold();
        int lat;
        start(8'h3C, 1'b0, 16'h7777);
        feed_puf(8'h0F);
        wait_ready(lat);
        black_key = 8'hFF; mode = 1'b1;
        feed_puf(8'hA5);
        repeat (10) @(negedge clk);
        chk(ready == 1'b1, "R7 ready holds", int'(ready), 1);
        chk(red_key == 8'h33, "R7 key holds", int'(red_key), 'h33);
    endtask

    task automatic t_late_black();
        int lat;
        start(8'h81, 1'b1, 16'h2468);
        black_key = 8'h7E;
        repeat (3) @(negedge clk);
        feed_puf(8'h18);
        wait_ready(lat);
        chk(red_key == 8'h99, "R2 late black ignored", int'(red_key), 'h99);
    endtask

    task automatic t_late_mode();
        int lat;
        start(8'h55, 1'b0, 16'h1357);
        mode = 1'b1;
        feed_puf(8'hF0);
        wait_ready(lat);
        chk(lat == 1, "R9 late mode ignored", lat, 1);
        chk(red_key == 8'hA5, "R9 value with late mode", int'(red_key), 'hA5);
    endtask

    task automatic t_early_valid();
        int lat;
        @(negedge clk);
        rst_n = 1'b0; black_key = 8'h0F; mode = 1'b0;
        puf_key = 8'hFF; puf_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R3 early strobe ignored", int'(ready), 0);
        puf_key = 8'h01;
        @(negedge clk);
        puf_valid = 1'b0;
        wait_ready(lat);
        chk(lat == 1 && red_key == 8'h0E, "R3 first accepted key used", int'(red_key), 'h0E);
    endtask

    initial begin
        t_unwrap(8'b10101101, 8'b11011011, 1'b0, 16'h1111, "known par");
        t_unwrap(8'b10101101, 8'b11011011, 1'b1, 16'h2222, "known ser");
        t_unwrap(8'hFF, 8'h00, 1'b0, 16'h3333, "ones par");
        t_unwrap(8'h00, 8'hFF, 1'b1, 16'h4444, "ones ser");
        t_unwrap(8'hA7, 8'hA7, 1'b1, 16'h5555, "cancel ser");
        t_unwrap(8'h01, 8'h80, 1'b1, 16'h6666, "ends ser");
        t_unwrap(8'h80, 8'h01, 1'b0, 16'h0000, "ends par");
        t_seeds();
        t_hold();
        t_late_black();
        t_late_mode();
        t_early_valid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule